// File: doc/BRIEF.md
# Program Order Tracking List

This block keeps the program order of in-flight instructions as a compact list of pointers, while letting those instructions commit in any order. Each list slot holds the tag of an instruction-pool slot, a flag marking memory instructions, and an ownership mask with one bit per entry of an undo buffer. The buffer itself lives outside this block. Dispatch appends at the tail. A commit may name any entry. That entry is removed, and every younger entry moves one place toward the head, so the list stays dense.

When an entry that is not the oldest commits, its ownership mask is folded into the entry just ahead of it. The bit for the undo entry the commit has just written is also set there. As a result, the older instruction now owns every value it would need to restore. When the oldest entry commits, the block reports its mask so the undo buffer can release those entries. The block also exposes the mask of the predecessor of the entry being committed. The undo buffer uses it to decide whether it can reuse an entry rather than allocate a new one.

An exception cuts the list back to just before the faulting entry. Memory instructions may leave only from the head. Instruction execution and register data are handled elsewhere.

Top module: `prog_order_list`

## Requirements
- R1: After reset, count is 0, full and head_valid are 0, and no release is reported.
- R2: A dispatch while not full appends its tag at the tail. head_tag always shows the oldest remaining tag, and a new entry starts with an all-zero ownership mask.
- R3: full is 1 exactly when count equals DEPTH. A dispatch while full is ignored, even when a commit is accepted in the same cycle.
- R4: An accepted commit removes the entry whose tag matches cmt_tag, wherever it sits. Younger entries keep their relative order and close the gap.
- R5: When an accepted commit is not at the head, the predecessor's mask becomes its old mask ORed with the committing entry's mask. If cmt_undo_valid is 1, bit cmt_undo_idx is also set.
- R6: When an accepted commit is at the head, release_valid is 1 in that same cycle and release_mask equals the head entry's mask. Otherwise release_valid is 0 and release_mask is all zeros.
- R7: An entry dispatched with disp_mem=1 commits only from the head. A commit of it at any other position is ignored (cmt_ok=0, list unchanged).
- R8: A commit whose tag matches no live entry is ignored.
- R9: An exception whose tag matches a live entry at position p (head is 0) sets count to p. A commit or dispatch in the same cycle is dropped. An exception whose tag matches nothing has no effect.
- R10: A dispatch accepted in the same cycle as a commit lands directly behind the compacted survivors.
- R11: pred_mask gives the mask of the entry just ahead of the one matching cmt_tag. It is all zeros when that entry is the head or no entry matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Append request |
| disp_tag | input | TAG_W | Pool tag to append |
| disp_mem | input | 1 | Appended instruction accesses memory |
| full | output | 1 | List full, dispatch must stall |
| cmt_valid | input | 1 | Commit request |
| cmt_tag | input | TAG_W | Pool tag of the committing instruction |
| cmt_undo_valid | input | 1 | Commit wrote an undo entry |
| cmt_undo_idx | input | $clog2(UNDO_N) | Index of that undo entry |
| cmt_ok | output | 1 | Commit accepted this cycle |
| pred_mask | output | UNDO_N | Ownership mask of the predecessor of cmt_tag |
| release_valid | output | 1 | Head commit, undo entries to release |
| release_mask | output | UNDO_N | Undo entries to release |
| exc_valid | input | 1 | Exception request |
| exc_tag | input | TAG_W | Pool tag of the faulting instruction |
| count | output | $clog2(DEPTH+1) | Live entries |
| head_valid | output | 1 | List not empty |
| head_tag | output | TAG_W | Tag of the oldest entry |

## Verification
The assertions assume that the live tags in the list are unique, so each match picks a single slot. They also assume the undo index is below UNDO_N. The stimulus draws every dispatched tag from tags that are not currently in the list, and keeps undo indices within the buffer size. Absent tags reach the block only on purpose, to exercise R8 and the no-effect case of R9.

// File: rtl/pol_pkg.sv
package pol_pkg;
   typedef enum logic [1:0] {
      POL_HOLD  = 2'd0,
      POL_SHIFT = 2'd1,
      POL_CUT   = 2'd2
   } pol_op_e;
endpackage

// File: rtl/pol_match.sv
module pol_match #(
   parameter int N = 8,
   parameter int W = 4,
   localparam int PW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]   vld,
   input  logic [N*W-1:0] tags,
   input  logic [W-1:0]   key,
   output logic           hit,
   output logic [PW-1:0]  pos
);
   // lowest live slot with an equal tag wins
   always_comb begin
      hit = 1'b0;
      pos = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vld[i] && tags[i*W +: W] == key) begin
            hit = 1'b1;
            pos = PW'(i);
         end
      end
   end
endmodule

// File: rtl/pol_dec.sv
module pol_dec #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          en,
   input  logic [IW-1:0] idx,
   output logic [N-1:0]  onehot
);
   always_comb onehot = en ? (N'(1) << idx) : '0;
endmodule

// File: rtl/prog_order_list.sv
module prog_order_list
   import pol_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 4,
   parameter int UNDO_N = 8,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int UIDX_W = $clog2(UNDO_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   input  logic [TAG_W-1:0]  disp_tag,
   input  logic              disp_mem,
   output logic              full,
   input  logic              cmt_valid,
   input  logic [TAG_W-1:0]  cmt_tag,
   input  logic              cmt_undo_valid,
   input  logic [UIDX_W-1:0] cmt_undo_idx,
   output logic              cmt_ok,
   output logic [UNDO_N-1:0] pred_mask,
   output logic              release_valid,
   output logic [UNDO_N-1:0] release_mask,
   input  logic              exc_valid,
   input  logic [TAG_W-1:0]  exc_tag,
   output logic [CNT_W-1:0]  count,
   output logic              head_valid,
   output logic [TAG_W-1:0]  head_tag
);
   generate
      if (DEPTH < 2)  begin : g_bad_depth  $error("DEPTH must be at least 2");  end
      if (UNDO_N < 2) begin : g_bad_undo   $error("UNDO_N must be at least 2"); end
      if (TAG_W < 1)  begin : g_bad_tag    $error("TAG_W must be positive");    end
   endgenerate

   logic [TAG_W-1:0]     tag_q  [DEPTH];
   logic [UNDO_N-1:0]    mask_q [DEPTH];
   logic [DEPTH-1:0]     mem_q;
   logic [CNT_W-1:0]     count_q;

   logic [TAG_W-1:0]     tag_n  [DEPTH];
   logic [UNDO_N-1:0]    mask_n [DEPTH];
   logic [DEPTH-1:0]     mem_n;
   logic [CNT_W-1:0]     count_n, cnt_rem;

   logic [DEPTH-1:0]       live;
   logic [DEPTH*TAG_W-1:0] tag_flat;
   logic                   c_hit, e_hit, exc_take, disp_ok, mem_blk;
   logic [IDX_W-1:0]       c_pos, e_pos;
   logic [UNDO_N-1:0]      undo_bit;
   pol_op_e                op;

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_flat
         assign live[g] = CNT_W'(g) < count_q;
         assign tag_flat[g*TAG_W +: TAG_W] = tag_q[g];
      end
   endgenerate

   pol_match #(.N(DEPTH), .W(TAG_W)) u_cmt_match (
      .vld(live), .tags(tag_flat), .key(cmt_tag), .hit(c_hit), .pos(c_pos));
   pol_match #(.N(DEPTH), .W(TAG_W)) u_exc_match (
      .vld(live), .tags(tag_flat), .key(exc_tag), .hit(e_hit), .pos(e_pos));
   pol_dec #(.N(UNDO_N)) u_undo_dec (
      .en(cmt_undo_valid), .idx(cmt_undo_idx), .onehot(undo_bit));

   assign full       = count_q == CNT_W'(DEPTH);
   assign count      = count_q;
   assign head_valid = count_q != '0;
   assign head_tag   = tag_q[0];

   assign exc_take = exc_valid && e_hit;
   assign mem_blk  = mem_q[c_pos] && (c_pos != '0);
   assign cmt_ok   = cmt_valid && c_hit && !mem_blk && !exc_take;
   assign disp_ok  = disp_valid && !full && !exc_take;

   assign pred_mask     = (c_hit && c_pos != '0) ? mask_q[c_pos - 1'b1] : '0;
   assign release_valid = cmt_ok && (c_pos == '0);
   assign release_mask  = release_valid ? mask_q[0] : '0;

   always_comb begin
      if (exc_take)    op = POL_CUT;
      else if (cmt_ok) op = POL_SHIFT;
      else             op = POL_HOLD;
   end

   always_comb begin
      cnt_rem = count_q - CNT_W'(op == POL_SHIFT);
      for (int i = 0; i < DEPTH; i++) begin
         int nx;
         nx = (i < DEPTH - 1) ? i + 1 : i;
         tag_n[i]  = tag_q[i];
         mask_n[i] = mask_q[i];
         mem_n[i]  = mem_q[i];
         if (op == POL_SHIFT && IDX_W'(i) >= c_pos) begin
            tag_n[i]  = tag_q[nx];
            mask_n[i] = mask_q[nx];
            mem_n[i]  = mem_q[nx];
         end
         if (op == POL_SHIFT && c_pos != '0 && IDX_W'(i) == c_pos - 1'b1)
            mask_n[i] = mask_q[i] | mask_q[c_pos] | undo_bit;
         if (disp_ok && CNT_W'(i) == cnt_rem) begin
            tag_n[i]  = disp_tag;
            mask_n[i] = '0;
            mem_n[i]  = disp_mem;
         end
      end
      count_n = (op == POL_CUT) ? CNT_W'(e_pos) : cnt_rem + CNT_W'(disp_ok);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         mem_q   <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            tag_q[i]  <= '0;
            mask_q[i] <= '0;
         end
      end else begin
         count_q <= count_n;
         mem_q   <= mem_n;
         for (int i = 0; i < DEPTH; i++) begin
            tag_q[i]  <= tag_n[i];
            mask_q[i] <= mask_n[i];
         end
      end
   end

   // R3
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));
   // R2
   append_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_ok && !cmt_ok) |=> count_q == $past(count_q) + 1'b1);
   // R9
   flush_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |=> count_q == CNT_W'($past(e_pos)));
   // R6
   release_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (release_valid && !disp_valid) |=> count_q == $past(count_q) - 1'b1);
   // R8
   absent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_valid && !c_hit && !disp_valid && !exc_valid) |=> $stable(count_q));
   // R7
   mem_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_valid && c_hit && c_pos != '0 && mem_q[c_pos] && !disp_valid && !exc_valid)
      |=> $stable(count_q));
endmodule

// File: tb/sim_prog_order_list.sv
module sim_prog_order_list;
   localparam int P  = 10;
   localparam int D  = 4;
   localparam int TW = 3;
   localparam int UN = 4;

   logic clk = 0, rst_n = 0;
   logic dv = 0, dm = 0, cv = 0, uv = 0, ev = 0;
   logic [TW-1:0] dt = '0, ct = '0, et = '0;
   logic [1:0] ui = '0;
   logic full, cmt_ok, release_valid, head_valid;
   logic [UN-1:0] pred_mask, release_mask;
   logic [2:0] count;
   logic [TW-1:0] head_tag;

   int errors = 0, checks = 0;
   int m_tag [D];
   int m_mask[D];
   int m_mem [D];
   int m_cnt = 0;

   always #(P/2) clk = ~clk;

   prog_order_list #(.DEPTH(D), .TAG_W(TW), .UNDO_N(UN)) u0 (
      .clk, .rst_n, .disp_valid(dv), .disp_tag(dt), .disp_mem(dm), .full,
      .cmt_valid(cv), .cmt_tag(ct), .cmt_undo_valid(uv), .cmt_undo_idx(ui),
      .cmt_ok, .pred_mask, .release_valid, .release_mask,
      .exc_valid(ev), .exc_tag(et), .count, .head_valid, .head_tag);

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(string req, bit idv, int idt, bit idm, bit icv, int ict,
                      bit iuv, int iui, bit iev, int iet);
      int mpos, epos, pr, rm;
      bit ok, rv, dok, xt;
      @(negedge clk);
      dv = idv; dt = TW'(idt); dm = idm; cv = icv; ct = TW'(ict);
      uv = iuv; ui = 2'(iui); ev = iev; et = TW'(iet);
      mpos = -1; epos = -1;
      for (int i = D - 1; i >= 0; i--) begin
         if (i < m_cnt && m_tag[i] == ict) mpos = i;
         if (i < m_cnt && m_tag[i] == iet) epos = i;
      end
      xt  = iev && epos >= 0;
      ok  = icv && mpos >= 0 && !(m_mem[mpos] != 0 && mpos != 0) && !xt;
      pr  = (mpos > 0) ? m_mask[mpos-1] : 0;
      rv  = ok && mpos == 0;
      rm  = rv ? m_mask[0] : 0;
      dok = idv && m_cnt < D && !xt;
      #1;
      if (icv) begin
         check(req, "cmt_ok", int'(cmt_ok), int'(ok));
         check({req, "/R11"}, "pred_mask", int'(pred_mask), pr);
         check({req, "/R6"}, "release_valid", int'(release_valid), int'(rv));
         check({req, "/R6"}, "release_mask", int'(release_mask), rm);
      end
      if (xt) m_cnt = epos;
      else begin
         if (ok) begin
            if (mpos > 0)
               m_mask[mpos-1] = m_mask[mpos-1] | m_mask[mpos] | (iuv ? (1 << iui) : 0);
            for (int i = mpos; i < D - 1; i++) begin
               m_tag[i] = m_tag[i+1]; m_mask[i] = m_mask[i+1]; m_mem[i] = m_mem[i+1];
            end
            m_cnt--;
         end
         if (dok) begin
            m_tag[m_cnt] = idt; m_mask[m_cnt] = 0; m_mem[m_cnt] = int'(idm); m_cnt++;
         end
      end
      @(posedge clk);
      #1;
      dv = 0; cv = 0; ev = 0; uv = 0;
      check(req, "count", int'(count), m_cnt);
      check({req, "/R3"}, "full", int'(full), int'(m_cnt == D));
      if (m_cnt > 0) check({req, "/R2"}, "head_tag", int'(head_tag), m_tag[0]);
   endtask

   task automatic disp(string req, int t, bit mem);
      cyc(req, 1, t, mem, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic cmt(string req, int t, bit u, int ix);
      cyc(req, 0, 0, 0, 1, t, u, ix, 0, 0);
   endtask

   task automatic drain(string req);
      while (m_cnt > 0) cmt(req, m_tag[0], 0, 0);
   endtask

   task automatic fill4();
      for (int t = 0; t < D; t++) disp("R2", t, 0);
   endtask

   initial begin
      #(P * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      check("R1", "count", int'(count), 0);
      check("R1", "full", int'(full), 0);
      check("R1", "head_valid", int'(head_valid), 0);
      check("R1", "release_valid", int'(release_valid), 0);

      // R2 / R3: fill, then a dispatch while full is dropped
      fill4();
      disp("R3", 5, 0);
      // R3: full blocks dispatch even with an accepted commit in the same cycle
      cyc("R3", 1, 6, 0, 1, 0, 0, 0, 0, 0);
      drain("R4");

      // R4 / R5 / R6: remove each position, then drain and read release masks
      for (int k = 0; k < D; k++) begin
         fill4();
         cmt("R4", k, 1, k);
         drain("R5");
      end

      // R5: chained merges gather into the head
      fill4();
      cmt("R5", 2, 1, 2);
      cmt("R5", 1, 1, 1);
      cmt("R5", 3, 1, 3);
      drain("R6");

      // R7: memory entry at position 1 waits for the head
      disp("R7", 0, 0);
      disp("R7", 1, 1);
      disp("R7", 2, 0);
      cmt("R7", 1, 0, 0);
      cmt("R7", 2, 1, 0);
      cmt("R7", 0, 0, 0);
      cmt("R7", 1, 0, 0);
      drain("R7");

      // R8: absent tags
      disp("R8", 3, 0);
      cmt("R8", 7, 1, 1);
      cmt("R8", 5, 0, 0);
      drain("R8");

      // R9: exception at each position, with a commit and a dispatch dropped
      for (int k = 0; k < D; k++) begin
         fill4();
         cyc("R9", 1, 7, 0, 1, 0, 1, 1, 1, k);
         cyc("R9", 0, 0, 0, 0, 0, 0, 0, 1, 6);
         drain("R9");
      end

      // R10: commit and append in the same cycle, at every removal position
      for (int k = 0; k < 3; k++) begin
         disp("R10", 0, 0);
         disp("R10", 1, 0);
         disp("R10", 2, 0);
         cyc("R10", 1, 6, 0, 1, k, 1, 3, 0, 0);
         drain("R10");
      end

      // R11: predecessor mask with a nonzero owner
      fill4();
      cmt("R11", 3, 1, 0);
      cmt("R11", 2, 1, 1);
      cyc("R11", 0, 0, 0, 1, 0, 0, 0, 0, 0);
      drain("R11");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule